// File: doc/BRIEF.md
# Load/Store Unit with Alignment Check

This unit stands between a processor's register file and a byte-addressed data memory. It carries out word loads, word stores, signed and unsigned byte loads, and byte stores. For each request it adds a sign-extended 16-bit byte offset to a 32-bit base value to form the effective address. It then drives a synchronous memory port that has byte enables. Consecutive words sit four addresses apart. Byte lanes are numbered big-endian within a word.

Word accesses must be word aligned. When the two low address bits are not both zero, the memory is left untouched and a fault reports the offending address one cycle later. Byte accesses may use any address. On a store, the unit moves the data byte to the lane that the address selects. On a load, it moves the selected lane down to the lowest byte of the result and extends it.

The memory returns read data one cycle after a read request. The unit signals completion of every accepted request one cycle after acceptance, with the tag of that request. It accepts a new request on every cycle in which the memory is not asking it to wait.

Top module: `mem_access_unit`

## Requirements
- R1: The effective address is base plus the offset sign-extended to 32 bits, wrapping modulo 2^32. For an access that does not fault, in the request cycle mem_en is high and mem_addr equals the effective address with bits 1:0 cleared.
- R2: A word load (req_op 0) completes one cycle after acceptance. In that cycle rsp_wb is high and rsp_data equals all 32 bits of mem_rdata.
- R3: A word store (req_op 1) at an aligned address drives mem_we high, mem_be 4'b1111 and mem_wdata equal to req_wdata, all in the request cycle.
- R4: A word load or word store whose effective address has nonzero bits 1:0 leaves mem_en and mem_we low. One cycle later it shows fault_valid high, fault_addr equal to the full effective address, and rsp_wb low.
- R5: Byte lanes are big-endian. Address bits 1:0 of 00, 01, 10 and 11 select data bits 31:24, 23:16, 15:8 and 7:0, and mem_be bits 3, 2, 1 and 0 respectively.
- R6: A signed byte load (req_op 2) puts the selected byte in rsp_data[7:0] and copies its bit 7 into bits 31:8. An unsigned byte load (req_op 3) fills bits 31:8 with zeros.
- R7: A byte store (req_op 4) never faults. It drives a one-hot mem_be that selects the addressed lane, and it places req_wdata[7:0] on all four lanes of mem_wdata.
- R8: rsp_done pulses, together with the request's tag, exactly one cycle after each accepted request. Back-to-back requests give back-to-back pulses, and no pulse appears without an accepted request.
- R9: While mem_wait is high, req_ready is low, no request is accepted, no memory access is made, and no completion or fault follows.
- R10: During and just after reset, rsp_done, rsp_wb and fault_valid are low.
- R11: Opcodes 5 to 7 are not accepted. They cause no memory access and no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code (0 word load, 1 word store, 2 signed byte load, 3 unsigned byte load, 4 byte store) |
| req_base | input | 32 | Base register value |
| req_ofs | input | 16 | Signed byte offset |
| req_wdata | input | 32 | Store data |
| req_tag | input | 5 | Destination tag |
| req_ready | output | 1 | Request can be accepted this cycle |
| mem_wait | input | 1 | Memory cannot take an access this cycle |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_be | output | 4 | Byte enables, bit 3 is bits 31:24 |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the read strobe |
| rsp_done | output | 1 | Completion pulse |
| rsp_tag | output | 5 | Tag of the completed request |
| rsp_wb | output | 1 | Register writeback enable |
| rsp_data | output | 32 | Load result |
| fault_valid | output | 1 | Alignment fault |
| fault_addr | output | 32 | Faulting effective address |

## Verification
On every cycle the assertions check the following. A fault never comes with a writeback or with a memory strobe in the previous cycle. A word store always enables all four lanes, and a byte store enables exactly one. Waiting blocks every access. Completions match accepted requests one cycle later. Only the bench's scenarios can show that the address arithmetic and its wraparound are correct, that each lane is the right one, and that sign and zero extension work. The bench compares loaded values against a shadow copy of memory that it updates from the intended store semantics.

// File: rtl/mau_pkg.sv
package mau_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LW  = 3'd0,
    OP_SW  = 3'd1,
    OP_LB  = 3'd2,
    OP_LBU = 3'd3,
    OP_SB  = 3'd4
  } mau_op_e;

  function automatic logic op_legal(input logic [OP_W-1:0] op);
    return op <= OP_SB;
  endfunction

  function automatic logic op_word(input logic [OP_W-1:0] op);
    return (op == OP_LW) || (op == OP_SW);
  endfunction

  function automatic logic op_store(input logic [OP_W-1:0] op);
    return (op == OP_SW) || (op == OP_SB);
  endfunction

  function automatic logic op_load(input logic [OP_W-1:0] op);
    return (op == OP_LW) || (op == OP_LB) || (op == OP_LBU);
  endfunction
endpackage

// File: rtl/mau_agu.sv
module mau_agu #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned LANE_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              is_word,
  output logic [ADDR_W-1:0] ea,
  output logic [LANE_W-1:0] lane,
  output logic              misalign
);
  localparam int unsigned EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ofs_ext;

  always_comb begin
    ofs_ext  = {{EXT_W{ofs[OFS_W-1]}}, ofs};
    ea       = base + ofs_ext;
    lane     = ea[LANE_W-1:0];
    misalign = is_word && (lane != '0);
  end
endmodule

// File: rtl/mau_st_steer.sv
module mau_st_steer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned LANES  = DATA_W / BYTE_W,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              is_byte,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [LANE_W-1:0] ADDR_OF_LANE = LANE_W'(LANES - 1 - g);
    assign be[g] = is_byte ? (lane == ADDR_OF_LANE) : 1'b1;
    assign wdata_out[g*BYTE_W +: BYTE_W] =
      is_byte ? wdata_in[BYTE_W-1:0] : wdata_in[g*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/mau_ld_extract.sv
module mau_ld_extract #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned LANES  = DATA_W / BYTE_W,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              is_byte,
  input  logic              sgn,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] data
);
  logic [BYTE_W-1:0] by_addr [LANES];
  logic [BYTE_W-1:0] sel;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign by_addr[g] = rdata[(LANES-1-g)*BYTE_W +: BYTE_W];
  end

  always_comb begin
    sel = by_addr[lane];
    if (is_byte) begin
      data = {{(DATA_W-BYTE_W){sgn & sel[BYTE_W-1]}}, sel};
    end else begin
      data = rdata;
    end
  end
endmodule

// File: rtl/mem_access_unit.sv
module mem_access_unit
  import mau_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned TAG_W  = 5,
  localparam int unsigned BYTE_W = 8,
  localparam int unsigned LANES  = DATA_W / BYTE_W,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OP_W-1:0]   req_op,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              req_ready,
  input  logic              mem_wait,
  output logic              mem_en,
  output logic              mem_we,
  output logic [LANES-1:0]  mem_be,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_done,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              rsp_wb,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fault_valid,
  output logic [ADDR_W-1:0] fault_addr
);
  // request decode
  logic              accept;
  logic              is_word;
  logic              is_store;
  logic              is_load;
  logic [ADDR_W-1:0] ea;
  logic [LANE_W-1:0] lane;
  logic              misalign;

  always_comb begin
    is_word   = op_word(req_op);
    is_store  = op_store(req_op);
    is_load   = op_load(req_op);
    req_ready = !mem_wait;
    accept    = req_valid && req_ready && op_legal(req_op);
  end

  mau_agu #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .LANE_W(LANE_W)
  ) u_agu (
    .base(req_base), .ofs(req_ofs), .is_word(is_word),
    .ea(ea), .lane(lane), .misalign(misalign)
  );

  mau_st_steer #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W)
  ) u_st (
    .is_byte(!is_word), .lane(lane), .wdata_in(req_wdata),
    .be(mem_be), .wdata_out(mem_wdata)
  );

  always_comb begin
    mem_en   = accept && !misalign;
    mem_we   = mem_en && is_store;
    mem_addr = {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  end

  // response stage: control flops reset, data flops clock-enabled
  logic              s_vld_q, s_vld_d;
  logic              s_flt_q, s_flt_d;
  logic              s_ld_q,  s_ld_d;
  logic              s_byte_q, s_byte_d;
  logic              s_sgn_q,  s_sgn_d;
  logic [LANE_W-1:0] s_lane_q, s_lane_d;
  logic [TAG_W-1:0]  s_tag_q,  s_tag_d;
  logic [ADDR_W-1:0] s_addr_q, s_addr_d;

  always_comb begin
    s_vld_d  = accept;
    s_flt_d  = accept && misalign;
    s_ld_d   = accept && is_load;
    s_byte_d = !is_word;
    s_sgn_d  = (req_op == OP_LB);
    s_lane_d = lane;
    s_tag_d  = req_tag;
    s_addr_d = ea;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_vld_q <= 1'b0;
      s_flt_q <= 1'b0;
      s_ld_q  <= 1'b0;
    end else begin
      s_vld_q <= s_vld_d;
      s_flt_q <= s_flt_d;
      s_ld_q  <= s_ld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s_byte_q <= s_byte_d;
      s_sgn_q  <= s_sgn_d;
      s_lane_q <= s_lane_d;
      s_tag_q  <= s_tag_d;
      s_addr_q <= s_addr_d;
    end
  end

  mau_ld_extract #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W)
  ) u_ld (
    .is_byte(s_byte_q), .sgn(s_sgn_q), .lane(s_lane_q),
    .rdata(mem_rdata), .data(rsp_data)
  );

  always_comb begin
    rsp_done    = s_vld_q;
    rsp_tag     = s_tag_q;
    rsp_wb      = s_vld_q && s_ld_q && !s_flt_q;
    fault_valid = s_vld_q && s_flt_q;
    fault_addr  = s_addr_q;
  end
endmodule

// File: rtl/mau_checker.sv
module mau_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       req_ready,
  input logic       mem_wait,
  input logic       mem_en,
  input logic       mem_we,
  input logic [3:0] mem_be,
  input logic       rsp_done,
  input logic       rsp_wb,
  input logic       fault_valid
);
  a_r4_fault_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> !rsp_wb);

  a_r4_fault_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> !$past(mem_en));

  a_r3_word_store_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_op == 3'd1) |-> mem_be == 4'hF);

  a_r7_byte_store_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_op == 3'd4) |-> $countones(mem_be) == 1);

  a_r9_wait_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wait |-> (!req_ready && !mem_en));

  a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op <= 3'd4) |=> rsp_done);

  a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || !req_ready) |=> !rsp_done);

  a_r11_illegal_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op > 3'd4) |-> !mem_en);
endmodule

bind mem_access_unit mau_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_ready(req_ready), .mem_wait(mem_wait), .mem_en(mem_en),
  .mem_we(mem_we), .mem_be(mem_be), .rsp_done(rsp_done),
  .rsp_wb(rsp_wb), .fault_valid(fault_valid)
);

// File: tb/tb_mem_access_unit.sv
`timescale 1ns/1ps
module tb_mem_access_unit;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [31:0] req_base;
  logic [15:0] req_ofs;
  logic [31:0] req_wdata;
  logic [4:0]  req_tag;
  logic        req_ready;
  logic        mem_wait;
  logic        mem_en;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        rsp_done;
  logic [4:0]  rsp_tag;
  logic        rsp_wb;
  logic [31:0] rsp_data;
  logic        fault_valid;
  logic [31:0] fault_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  mem_access_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_ofs(req_ofs), .req_wdata(req_wdata),
    .req_tag(req_tag), .req_ready(req_ready), .mem_wait(mem_wait),
    .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_done(rsp_done),
    .rsp_tag(rsp_tag), .rsp_wb(rsp_wb), .rsp_data(rsp_data),
    .fault_valid(fault_valid), .fault_addr(fault_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // memory model: 16 words, synchronous read, byte-enabled write
  logic [31:0] mem  [16];
  logic [31:0] gold [16];

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[5:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[5:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ea_of(input logic [31:0] b, input logic [15:0] o);
    logic [31:0] se;
    se = {{16{o[15]}}, o};
    return b + se;
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [31:0] b,
                        input logic [15:0] o, input logic [31:0] wd,
                        input logic [4:0] tg);
    logic [31:0] ea;
    logic        mis, ld, st;
    logic [3:0]  idx;
    logic [1:0]  ln;
    logic [7:0]  by;
    logic [31:0] exp_data;
    ea  = ea_of(b, o);
    mis = (op <= 3'd1) && (ea[1:0] != 2'b00);
    ld  = (op == 3'd0) || (op == 3'd2) || (op == 3'd3);
    st  = (op == 3'd1) || (op == 3'd4);
    idx = ea[5:2];
    ln  = ea[1:0];
    by  = gold[idx][(3-ln)*8 +: 8];
    if (op == 3'd0) exp_data = gold[idx];
    else if (op == 3'd2) exp_data = {{24{by[7]}}, by};
    else exp_data = {24'h0, by};

    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_base = b; req_ofs = o;
    req_wdata = wd; req_tag = tg;
    #1;
    chk(mem_en == !mis, mis ? "R4 mem_en on misalign" : "R1 mem_en", {31'h0, mem_en}, {31'h0, !mis});
    if (!mis)
      chk(mem_addr == {ea[31:2], 2'b00}, "R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
    chk(mem_we == (st && !mis), "R4 mem_we", {31'h0, mem_we}, {31'h0, st && !mis});
    if (op == 3'd1 && !mis) begin
      chk(mem_be == 4'hF, "R3 be", {28'h0, mem_be}, 32'hF);
      chk(mem_wdata == wd, "R3 wdata", mem_wdata, wd);
      gold[idx] = wd;
    end
    if (op == 3'd4) begin
      chk(mem_be == (4'b1000 >> ln), "R5 R7 be lane", {28'h0, mem_be}, {28'h0, 4'b1000 >> ln});
      chk(mem_wdata == {4{wd[7:0]}}, "R7 wdata replicate", mem_wdata, {4{wd[7:0]}});
      gold[idx][(3-ln)*8 +: 8] = wd[7:0];
    end

    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(rsp_done == 1'b1, "R8 done", {31'h0, rsp_done}, 32'h1);
    chk(rsp_tag == tg, "R8 tag", {27'h0, rsp_tag}, {27'h0, tg});
    chk(fault_valid == mis, "R4 fault_valid", {31'h0, fault_valid}, {31'h0, mis});
    chk(rsp_wb == (ld && !mis), "R2 R4 rsp_wb", {31'h0, rsp_wb}, {31'h0, ld && !mis});
    if (mis) chk(fault_addr == ea, "R4 fault_addr", fault_addr, ea);
    if (ld && !mis) begin
      if (op == 3'd0) chk(rsp_data == exp_data, "R2 word data", rsp_data, exp_data);
      else if (op == 3'd2) chk(rsp_data == exp_data, "R5 R6 signed byte", rsp_data, exp_data);
      else chk(rsp_data == exp_data, "R5 R6 unsigned byte", rsp_data, exp_data);
    end
  endtask

  initial begin
    automatic logic [15:0] ofs_set [8] = '{16'd0, 16'd1, 16'd2, 16'd3,
                                           16'd4, 16'hFFFC, 16'hFFFF, 16'd8};
    for (int i = 0; i < 16; i++) begin
      mem[i]  = 32'h8A3F_C512 ^ {4{i[7:0]}};
      gold[i] = 32'h8A3F_C512 ^ {4{i[7:0]}};
    end
    rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd0; req_base = '0;
    req_ofs = '0; req_wdata = '0; req_tag = '0; mem_wait = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(!rsp_done && !rsp_wb && !fault_valid, "R10 reset outputs",
        {29'h0, rsp_done, rsp_wb, fault_valid}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(!rsp_done && !rsp_wb && !fault_valid, "R10 after release",
        {29'h0, rsp_done, rsp_wb, fault_valid}, 32'h0);

    // word stores and loads over base alignment x offset
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 8; k++)
        run_op(3'd1, 32'h20 + b, ofs_set[k], 32'hC0DE_0000 + 32'(b*8 + k), 5'(b*8 + k));
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 8; k++)
        run_op(3'd0, 32'h20 + b, ofs_set[k], 32'h0, 5'(k));

    // byte loads and stores over every lane
    for (int a = 0; a < 16; a++) begin
      run_op(3'd2, 32'h40 + a, 16'd0, 32'h0, 5'(a));
      run_op(3'd3, 32'h40 + a, 16'd0, 32'h0, 5'(a));
      run_op(3'd4, 32'h40 + a, 16'hFFF0, 32'h0000_009C ^ 32'(a), 5'(a));
      run_op(3'd2, 32'h30 + a, 16'd0, 32'h0, 5'(a));
      run_op(3'd3, 32'h30 + a, 16'd0, 32'h0, 5'(a));
      run_op(3'd4, 32'h30 + a, 16'd0, 32'h0000_005A, 5'(a));
      run_op(3'd0, 32'h30 + (a & ~3), 16'd0, 32'h0, 5'(a));
    end

    // wraparound of the address sum (R1)
    run_op(3'd1, 32'hFFFF_FFFC, 16'd8, 32'h1234_5678, 5'd3);
    run_op(3'd0, 32'h0000_0010, 16'hFFEC, 32'h0, 5'd4);
    run_op(3'd0, 32'h0000_0004, 16'd0, 32'h0, 5'd5);
    run_op(3'd1, 32'h0000_0003, 16'hFFFC, 32'h0, 5'd6);

    // back-to-back loads (R8)
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd0; req_base = 32'h0; req_ofs = 16'd4; req_tag = 5'd9;
    @(negedge clk);
    req_tag = 5'd10; req_ofs = 16'd8;
    #1;
    chk(rsp_done && rsp_tag == 5'd9, "R8 first of pair", {27'h0, rsp_tag}, 32'd9);
    chk(rsp_data == gold[1], "R2 first of pair data", rsp_data, gold[1]);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(rsp_done && rsp_tag == 5'd10, "R8 second of pair", {27'h0, rsp_tag}, 32'd10);
    chk(rsp_data == gold[2], "R2 second of pair data", rsp_data, gold[2]);
    @(negedge clk);
    #1;
    chk(!rsp_done, "R8 idle no done", {31'h0, rsp_done}, 32'h0);

    // memory wait (R9): misaligned word store and a byte store while waiting
    @(negedge clk);
    mem_wait = 1'b1; req_valid = 1'b1; req_op = 3'd1; req_base = 32'h21; req_ofs = 16'd0;
    #1;
    chk(!req_ready && !mem_en, "R9 ready/en low", {30'h0, req_ready, mem_en}, 32'h0);
    @(negedge clk);
    req_op = 3'd4; req_wdata = 32'hFF;
    #1;
    chk(!rsp_done && !fault_valid, "R9 no fault or done", {30'h0, rsp_done, fault_valid}, 32'h0);
    chk(!mem_en, "R9 byte store blocked", {31'h0, mem_en}, 32'h0);
    @(negedge clk);
    req_valid = 1'b0; mem_wait = 1'b0;
    #1;
    chk(!rsp_done, "R9 no done after wait", {31'h0, rsp_done}, 32'h0);
    run_op(3'd0, 32'h20, 16'd0, 32'h0, 5'd1);

    // illegal opcodes (R11)
    for (int op = 5; op < 8; op++) begin
      @(negedge clk);
      req_valid = 1'b1; req_op = 3'(op); req_base = 32'h20; req_ofs = 16'd0;
      #1;
      chk(!mem_en, "R11 no access", {31'h0, mem_en}, 32'h0);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(!rsp_done, "R11 no done", {31'h0, rsp_done}, 32'h0);
    end
    run_op(3'd0, 32'h20, 16'd0, 32'h0, 5'd2);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule